// File: doc/BRIEF.md
# Serial GPIO Edge Event Detector

This block watches a set of input pins that a serial shifter captures elsewhere and hands over as a parallel word with an update strobe. The pins are grouped into banks of eight. On each strobe the block compares the new capture with the one it holds. Every pin has a 2-bit edge selection: rising, falling, both, or off. A selected edge sets that pin's bit in a per-bank status byte.

Status bits stay set until software writes ones to them. One interrupt line is raised whenever any status bit in any bank is set. A small register interface gives access to the captured pin values, the edge selections and the status bytes. It takes byte and halfword writes and has a combinational read path.

Top module: `sgpio_event_detect`

## Requirements
- R1: After reset all edge selections, status bits and held samples are zero, and `irq` is low.
- R2: On a cycle with `pin_strobe` high, the block stores `pin_data`. Bank b's byte (pins 8b..8b+7, pin 8b+k at bit k) reads back at address 0x08+b. Without a strobe the stored value does not change.
- R3: Bank b's edge selection is a 16-bit register at address 0x10+2b, with pin k of the bank at bits [2k+1:2k]. A halfword write (`reg_half`=1) at the even address writes all 16 bits. A byte write (`reg_half`=0) at the even address writes bits [7:0] from `reg_wdata[7:0]`. A byte write at the odd address 0x11+2b writes bits [15:8] from `reg_wdata[7:0]`. A read at the even address returns all 16 bits. A read at the odd address returns bits [15:8] in `reg_rdata[7:0]`.
- R4: Selection bit 0 (value 1) enables rising edges. A pin that was 0 in the held sample and is 1 in the strobed capture sets its status bit.
- R5: Selection bit 1 (value 2) enables falling edges. A pin that was 1 in the held sample and is 0 in the strobed capture sets its status bit. Value 1 ignores falling edges and value 2 ignores rising edges.
- R6: Selection value 3 detects both edges. Value 0 never sets the pin's status bit.
- R7: Bank b's status byte reads at address 0x20+b, with pin k of the bank at bit k. A write there clears each bit whose `reg_wdata` bit is 1 and leaves bits written with 0 unchanged.
- R8: If an edge event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R9: `irq` is high exactly while at least one status bit is set. It follows the status registers in the same cycle, with no extra register stage.
- R10: Status bits are set only in a cycle with `pin_strobe` high. Pin changes between strobes produce no event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_data | input | NUM_BANKS*8 | Parallel word of captured pin values |
| pin_strobe | input | 1 | Marks a new capture on `pin_data` |
| reg_addr | input | 6 | Register byte address |
| reg_wr | input | 1 | Write enable |
| reg_half | input | 1 | 1 = halfword access, 0 = byte access |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Combined event interrupt |

## Verification
The bench uses the default of eight banks, so all 64 pins are present. This brings the top addresses into reach: sample byte 0x0F, selection halfword 0x1E/0x1F and status byte 0x27. An off-by-one in bank decoding at the upper end shows up there. Random captures, selections and partial clears run against a bit-level model. Directed cases cover byte writes to the odd selection address, each edge selection value, zero-bit writes to status, and an event that lands in the same cycle as its clear.

// File: rtl/sgpio_event_detect.sv
module sgpio_event_detect #(
  parameter int NUM_BANKS = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_BANKS*8-1:0] pin_data,
  input  logic                   pin_strobe,
  input  logic [5:0]             reg_addr,
  input  logic                   reg_wr,
  input  logic                   reg_half,
  input  logic [15:0]            reg_wdata,
  output logic [15:0]            reg_rdata,
  output logic                   irq
);
  localparam int NPINS = NUM_BANKS * 8;

  logic [NPINS-1:0]                 sample_q, status_q, rise_en, fall_en, evt, clr;
  logic [NUM_BANKS-1:0][15:0]       cfg_q;
  logic [NUM_BANKS-1:0]             lo_wr, hi_wr;
  logic [7:0]                       hi_data;

  genvar g;
  for (g = 0; g < NPINS; g++) begin : g_pin
    assign rise_en[g] = cfg_q[g/8][2*(g%8)];
    assign fall_en[g] = cfg_q[g/8][2*(g%8)+1];
  end

  assign evt = pin_strobe ? ((pin_data & ~sample_q & rise_en) |
                             (~pin_data & sample_q & fall_en)) : '0;
  assign hi_data = reg_half ? reg_wdata[15:8] : reg_wdata[7:0];
  assign irq = |status_q;

  always_comb begin
    clr = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      lo_wr[b] = reg_wr && reg_addr == 6'(16 + 2*b);
      hi_wr[b] = reg_wr && ((reg_addr == 6'(16 + 2*b) && reg_half) ||
                            (reg_addr == 6'(17 + 2*b) && !reg_half));
      if (reg_wr && reg_addr == 6'(32 + b)) clr[8*b +: 8] = reg_wdata[7:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sample_q <= '0;
      status_q <= '0;
      cfg_q    <= '0;
    end else begin
      if (pin_strobe) sample_q <= pin_data;
      status_q <= (status_q & ~clr) | evt;
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (lo_wr[b]) cfg_q[b][7:0]  <= reg_wdata[7:0];
        if (hi_wr[b]) cfg_q[b][15:8] <= hi_data;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (reg_addr == 6'(8 + b))      reg_rdata = {8'h00, sample_q[8*b +: 8]};
      if (reg_addr == 6'(16 + 2*b))   reg_rdata = cfg_q[b];
      if (reg_addr == 6'(17 + 2*b))   reg_rdata = {8'h00, cfg_q[b][15:8]};
      if (reg_addr == 6'(32 + b))     reg_rdata = {8'h00, status_q[8*b +: 8]};
    end
  end

  assert_sample_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_strobe |=> $stable(sample_q));

  assert_cfg_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|lo_wr) && !(|hi_wr)) |=> $stable(cfg_q));

  assert_set_on_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_strobe |=> ((status_q & ~$past(status_q)) == '0));

  assert_irq_drop_by_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(reg_wr));

  assert_irq_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q != '0) |-> irq);
endmodule

// File: tb/tb_sgpio_event_detect.sv
module tb_sgpio_event_detect;
  localparam int NB = 8;
  localparam int NP = NB * 8;

  logic clk = 0, rst_n = 0, pin_strobe = 0, reg_wr = 0, reg_half = 0;
  logic [NP-1:0] pin_data = '0;
  logic [5:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic irq;

  int checks = 0, fails = 0;
  logic [NP-1:0] m_samp = '0, m_sts = '0;
  logic [NB-1:0][15:0] m_cfg = '0;

  sgpio_event_detect #(.NUM_BANKS(NB)) dut (.*);

  always #10 clk = ~clk;

  function automatic logic [NP-1:0] mask_of(input int bitsel);
    logic [NP-1:0] m;
    for (int p = 0; p < NP; p++) m[p] = m_cfg[p/8][2*(p%8)+bitsel];
    return m;
  endfunction

  function automatic logic [15:0] exp_read(input logic [5:0] a);
    for (int b = 0; b < NB; b++) begin
      if (a == 6'(8 + b))    return {8'h00, m_samp[8*b +: 8]};
      if (a == 6'(16 + 2*b)) return m_cfg[b];
      if (a == 6'(17 + 2*b)) return {8'h00, m_cfg[b][15:8]};
      if (a == 6'(32 + b))   return {8'h00, m_sts[8*b +: 8]};
    end
    return 16'h0;
  endfunction

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(input string req, input logic [5:0] a);
    @(negedge clk);
    reg_addr = a;
    #1 chk(req, reg_rdata, exp_read(a));
  endtask

  task automatic chk_irq(input string req);
    #1 chk(req, {15'h0, irq}, {15'h0, m_sts != '0});
  endtask

  // One cycle: optional strobe, optional register write.
  task automatic cyc(input logic s, input logic [NP-1:0] d,
                     input logic w, input logic h, input logic [5:0] a, input logic [15:0] wd);
    logic [NP-1:0] ev, c;
    @(negedge clk);
    pin_strobe = s; pin_data = d; reg_wr = w; reg_half = h; reg_addr = a; reg_wdata = wd;
    ev = s ? ((d & ~m_samp & mask_of(0)) | (~d & m_samp & mask_of(1))) : '0;
    c = '0;
    if (w) for (int b = 0; b < NB; b++) begin
      if (a == 6'(32 + b)) c[8*b +: 8] = wd[7:0];
      if (a == 6'(16 + 2*b)) begin
        m_cfg[b][7:0] = wd[7:0];
        if (h) m_cfg[b][15:8] = wd[15:8];
      end
      if (a == 6'(17 + 2*b) && !h) m_cfg[b][15:8] = wd[7:0];
    end
    m_sts = (m_sts & ~c) | ev;
    if (s) m_samp = d;
    @(negedge clk);
    pin_strobe = 0; reg_wr = 0;
  endtask

  task automatic all_regs(input string req);
    for (int b = 0; b < NB; b++) begin
      rd(req, 6'(8 + b)); rd(req, 6'(16 + 2*b)); rd(req, 6'(32 + b));
    end
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    all_regs("R1");
    chk_irq("R1");

    // R3 byte writes at even/odd of top bank, halfword readback
    cyc(0, '0, 1, 0, 6'h1E, 16'hAA55); rd("R3", 6'h1E);
    cyc(0, '0, 1, 0, 6'h1F, 16'h0031); rd("R3", 6'h1F); rd("R3", 6'h1E);
    cyc(0, '0, 1, 1, 6'h1E, 16'h0001); rd("R3", 6'h1E);

    // R4 rising on pin 63 (bank 7 pin 7): set cfg bits [15:14]=01
    cyc(0, '0, 1, 1, 6'h1E, 16'h4000);
    cyc(1, 64'h8000_0000_0000_0000, 0, 0, 0, 0); rd("R4", 6'h27); chk_irq("R9");
    cyc(0, '0, 1, 0, 6'h27, 16'h0080); rd("R7", 6'h27); chk_irq("R9");
    // R5 falling ignored by rising-only selection
    cyc(1, '0, 0, 0, 0, 0); rd("R5", 6'h27);
    // R5 falling-only
    cyc(0, '0, 1, 1, 6'h10, 16'h0002);
    cyc(1, 64'h1, 0, 0, 0, 0); rd("R5", 6'h20);
    cyc(1, 64'h0, 0, 0, 0, 0); rd("R5", 6'h20); rd("R2", 6'h08);
    // R7 zeros have no effect, then clear
    cyc(0, '0, 1, 0, 6'h20, 16'h00FE); rd("R7", 6'h20);
    cyc(0, '0, 1, 0, 6'h20, 16'h00FF); rd("R7", 6'h20); chk_irq("R9");
    // R6 both and off
    cyc(0, '0, 1, 1, 6'h12, 16'h0003);
    cyc(1, 64'h100, 0, 0, 0, 0); rd("R6", 6'h21);
    cyc(1, 64'h000, 0, 0, 0, 0); rd("R6", 6'h21);
    cyc(0, '0, 1, 0, 6'h21, 16'h00FF);
    cyc(0, '0, 1, 1, 6'h12, 16'h0000);
    cyc(1, 64'h100, 0, 0, 0, 0); rd("R6", 6'h21);
    // R10 pin changes without strobe
    cyc(0, '0, 1, 1, 6'h12, 16'hFFFF);
    cyc(0, 64'hFF00, 0, 0, 0, 0); rd("R10", 6'h21); rd("R2", 6'h09);
    // R8 event and clear in the same cycle
    cyc(1, 64'h0, 1, 0, 6'h21, 16'h00FF); rd("R8", 6'h21); chk_irq("R8");
    cyc(0, '0, 1, 0, 6'h21, 16'h00FF);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      int op = $urandom % 4;
      int b  = $urandom % NB;
      case (op)
        0: cyc(1, {$urandom, $urandom}, 0, 0, 0, 0);
        1: cyc(0, '0, 1, $urandom % 2, 6'(16 + 2*b + ($urandom % 2)), 16'($urandom));
        2: cyc(0, '0, 1, 0, 6'(32 + b), 16'($urandom));
        default: cyc(1, {$urandom, $urandom}, 1, 0, 6'(32 + b), 16'($urandom));
      endcase
      if (i % 40 == 39) begin
        all_regs("R4");
        rd("R3", 6'(17 + 2*b));
        chk_irq("R9");
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule